// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer that joins two clock domains. A producer writes 9-bit words on `wr_clk` and a consumer takes them on `rd_clk`. The buffer holds `2**ADDR_W` words. Each domain sees a pointer from the other side only as Gray code passed through two flip-flops. Each domain keeps its own pair of status flags. On the write side these are full and almost-full, updated only on `wr_clk`. On the read side these are empty and almost-empty, updated only on `rd_clk`.

The thresholds behind the two "almost" flags sit in four byte registers. These are loaded through the normal write data port. The input `wr_en2_ld` has two roles. Its level while reset is held low fixes the operating mode until the next reset. In normal mode it acts as a second write enable. In load mode it selects offset access. The same pin, driven together with both read enables, steps through the offset registers and returns them on the read data port.

A read needs both read enables. The `out_en` input gates the output word: it shows the held word when high and forces zeros when low. The design assumes two things. First, the offsets and `wr_en2_ld` stay quiet in the other domain while offsets are loaded or read back. Second, `rst_n` is held low for at least two edges of each clock.

Top module: `dual_clk_pflag_fifo`

## Requirements
- R1: For two or more edges of both clocks with `rst_n` low, the block resets to the following state. Empty and almost_empty are 1, full and almost_full are 0, the held output word is 0, both offsets are 7, and both register-access slots point at slot 0.
- R2: Words leave in the order they were accepted. Each accepted read loads the oldest stored word into the held output word.
- R3: A write request made while full is 1 stores nothing. Full becomes 1 on the `wr_clk` edge after which the write side counts `2**ADDR_W` words. The write side counts words as its pointer minus the synchronized read pointer.
- R4: A read happens only when `rd_en1` and `rd_en2` are both 1. A read request made while empty is 1 changes neither the read pointer nor the held output word.
- R5: almost_full is 1 exactly when the write-side count is at least `2**ADDR_W - AF`. AF is the almost-full offset.
- R6: almost_empty is 1 exactly when the read-side count is at most AE. The read side counts the synchronized write pointer minus its own pointer. AE is the almost-empty offset.
- R7: With both clocks from one source, a write into an empty FIFO clears empty on the third `rd_clk` edge after the write edge. A pointer's Gray code changes in at most one bit per edge.
- R8: If `wr_en2_ld` is 1 during reset, the block runs in normal mode. In that mode a word is stored only when `wr_en1` and `wr_en2_ld` are both 1.
- R9: If `wr_en2_ld` is 0 during reset, the block runs in load mode. In that mode, `wr_en1` with `wr_en2_ld` = 1 writes `wr_data[7:0]` into the next offset slot, and bit 8 is dropped. The slot order is 0 = AE low byte, 1 = AE high byte, 2 = AF low byte, 3 = AF high byte. After slot 3 the order wraps to slot 0. Each offset is {high, low} taken modulo `2**ADDR_W`.
- R10: In load mode, `rd_en1`, `rd_en2` and `wr_en2_ld` all at 1 place {1'b0, slot byte} in the held output word. They step a separate readback slot in the same order, wrapping after slot 3, and do not pop the FIFO.
- R11: With `out_en` at 0, `rd_data` is all zeros. With `out_en` at 1, `rd_data` shows the held output word.
- R12: In load mode a word is stored when `wr_en1` is 1 and `wr_en2_ld` is 0. An offset write does not store a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both domains |
| wr_data | input | DATA_W | Write word, or offset byte in bits 7:0 |
| wr_en1 | input | 1 | Primary write enable |
| wr_en2_ld | input | 1 | Second write enable or offset-access select; mode chosen by its level in reset |
| rd_en1 | input | 1 | First read enable |
| rd_en2 | input | 1 | Second read enable |
| out_en | input | 1 | Output gate for rd_data |
| rd_data | output | DATA_W | Held output word, or zero when gated |
| full | output | 1 | FIFO full, write domain |
| almost_full | output | 1 | Count at or above depth minus AF, write domain |
| empty | output | 1 | FIFO empty, read domain |
| almost_empty | output | 1 | Count at or below AE, read domain |

## Verification
The bench fills the buffer past its capacity and keeps writing while reading at a sparse rate. A design that miscounted the wrapped pointer would overwrite live words or never raise full. It reads past empty, where a design that ignored the flag would repeat stale words or skip data. It measures the exact number of edges before empty clears, which catches an extra or missing synchronizer stage. It programs an almost-full offset above 255, which catches a design that drops the high byte. It loads five offset bytes and reads back five, so a slot counter that does not wrap, or that shares its position with the load side, returns the wrong byte.

// File: rtl/pf_fifo_pkg.sv
// Package for the programmable-flag FIFO.
// Holds the offset slot order and the offset bank type.
// Assumes offsets are built from two bytes each.
package pf_fifo_pkg;

    localparam int OFS_BYTE_W = 8;
    localparam int OFS_SLOTS  = 4;

    // Slot order is behaviour: loads and readbacks walk it in this sequence
    typedef enum logic [1:0] {
        SLOT_AE_LO = 2'd0,
        SLOT_AE_HI = 2'd1,
        SLOT_AF_LO = 2'd2,
        SLOT_AF_HI = 2'd3
    } ofs_slot_e;

    typedef logic [OFS_SLOTS-1:0][OFS_BYTE_W-1:0] ofs_bank_t;

    // Advance to the following slot, wrapping after the last
    function automatic ofs_slot_e next_slot(input ofs_slot_e s);
        return ofs_slot_e'(s + 2'd1);
    endfunction

endpackage

// File: rtl/pf_gray_sync.sv
// Two-flop synchronizer for a Gray-coded pointer, with Gray-to-binary decode.
// Assumes the source changes at most one bit per source-clock edge.
module pf_gray_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Capture the foreign pointer through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_in;
            stage2_q <= stage1_q;
        end
    end

    // Each binary bit is the XOR of all Gray bits at or above it
    for (genvar i = 0; i < W; i++) begin : g_dec
        assign bin_out[i] = ^stage2_q[W-1:i];
    end

endmodule

// File: rtl/pf_dpram.sv
// Storage array: one synchronous write port, one combinational read port.
// Assumes the read side registers the word it takes.
module pf_dpram #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 10
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted word
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pf_wr_ctrl.sv
// Write-domain control. Owns the write pointer, full and almost-full flags,
// the mode captured at reset, and the four offset byte registers with their
// load slot. Assumes rptr_bin is already synchronized into this domain.
module pf_wr_ctrl
    import pf_fifo_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DEF_OFS = 7,
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en1,
    input  logic                  en2_ld,
    input  logic [OFS_BYTE_W-1:0] ofs_din,
    input  logic [PTR_W-1:0]      rptr_bin,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [PTR_W-1:0]      wbin,
    output logic [PTR_W-1:0]      wgray,
    output logic                  full,
    output logic                  almost_full,
    output ofs_bank_t             ofs,
    output logic                  load_mode
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [2*OFS_BYTE_W-1:0] DEF_WORD = (2*OFS_BYTE_W)'(DEF_OFS);

    logic [PTR_W-1:0] wbin_q, wbin_nxt, wgray_q, cnt_nxt, af_thr;
    logic             full_q, af_q, mode_q;
    logic             fifo_req, wr_go, ofs_we;
    logic [ADDR_W-1:0] af_off;
    ofs_bank_t        ofs_q;
    ofs_slot_e        slot_q;

    // Mode is latched from the shared pin while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= !en2_ld;
        end
    end

    // Decode the write request and the offset load for the current mode
    always_comb begin
        fifo_req = en1 && (mode_q ? !en2_ld : en2_ld);
        wr_go    = fifo_req && !full_q;
        ofs_we   = en1 && en2_ld && mode_q;
        wbin_nxt = wbin_q + PTR_W'(wr_go);
        cnt_nxt  = wbin_nxt - rptr_bin;
        af_off   = ADDR_W'({ofs_q[SLOT_AF_HI], ofs_q[SLOT_AF_LO]});
        af_thr   = PTR_W'(DEPTH) - {1'b0, af_off};
    end

    // Pointer and write-side flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            full_q  <= 1'b0;
            af_q    <= 1'b0;
        end else begin
            wbin_q  <= wbin_nxt;
            wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
            full_q  <= (cnt_nxt == PTR_W'(DEPTH));
            af_q    <= (cnt_nxt >= af_thr);
        end
    end

    // Offset byte registers and their load slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q[SLOT_AE_LO] <= DEF_WORD[OFS_BYTE_W-1:0];
            ofs_q[SLOT_AE_HI] <= DEF_WORD[2*OFS_BYTE_W-1:OFS_BYTE_W];
            ofs_q[SLOT_AF_LO] <= DEF_WORD[OFS_BYTE_W-1:0];
            ofs_q[SLOT_AF_HI] <= DEF_WORD[2*OFS_BYTE_W-1:OFS_BYTE_W];
            slot_q            <= SLOT_AE_LO;
        end else if (ofs_we) begin
            ofs_q[slot_q] <= ofs_din;
            slot_q        <= next_slot(slot_q);
        end
    end

    assign mem_we      = wr_go;
    assign mem_addr    = wbin_q[ADDR_W-1:0];
    assign wbin        = wbin_q;
    assign wgray       = wgray_q;
    assign full        = full_q;
    assign almost_full = af_q;
    assign ofs         = ofs_q;
    assign load_mode   = mode_q;

endmodule

// File: rtl/pf_rd_ctrl.sv
// Read-domain control. Owns the read pointer, empty and almost-empty flags,
// the held output word and the offset readback slot. Assumes wptr_bin is
// synchronized and the offset bank is quiet while it is being used here.
module pf_rd_ctrl
    import pf_fifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 10,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en1,
    input  logic              en2,
    input  logic              ld,
    input  logic [PTR_W-1:0]  wptr_bin,
    input  logic [DATA_W-1:0] mem_rdata,
    input  ofs_bank_t         ofs,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PTR_W-1:0]  rbin,
    output logic [PTR_W-1:0]  rgray,
    output logic [DATA_W-1:0] rd_q,
    output logic              empty,
    output logic              almost_empty,
    output logic              load_mode
);

    logic [PTR_W-1:0]  rbin_q, rbin_nxt, rgray_q, cnt_nxt;
    logic [DATA_W-1:0] hold_q;
    logic              empty_q, ae_q, mode_q;
    logic              both, rback, rd_go;
    logic [ADDR_W-1:0] ae_off;
    ofs_slot_e         slot_q;

    // Mode is latched from the shared pin while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= !ld;
        end
    end

    // Decode a FIFO read versus an offset readback
    always_comb begin
        both     = en1 && en2;
        rback    = both && ld && mode_q;
        rd_go    = both && !rback && !empty_q;
        rbin_nxt = rbin_q + PTR_W'(rd_go);
        cnt_nxt  = wptr_bin - rbin_nxt;
        ae_off   = ADDR_W'({ofs[SLOT_AE_HI], ofs[SLOT_AE_LO]});
    end

    // Pointer and read-side flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            empty_q <= 1'b1;
            ae_q    <= 1'b1;
        end else begin
            rbin_q  <= rbin_nxt;
            rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
            empty_q <= (cnt_nxt == '0);
            ae_q    <= (cnt_nxt <= {1'b0, ae_off});
        end
    end

    // Held output word and readback slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            slot_q <= SLOT_AE_LO;
        end else if (rd_go) begin
            hold_q <= mem_rdata;
        end else if (rback) begin
            hold_q <= DATA_W'(ofs[slot_q]);
            slot_q <= next_slot(slot_q);
        end
    end

    assign mem_addr     = rbin_q[ADDR_W-1:0];
    assign rbin         = rbin_q;
    assign rgray        = rgray_q;
    assign rd_q         = hold_q;
    assign empty        = empty_q;
    assign almost_empty = ae_q;
    assign load_mode    = mode_q;

endmodule

// File: rtl/dual_clk_pflag_fifo.sv
// Top of the dual-clock FIFO with programmable threshold flags.
// Ties storage, both domain controllers and the two pointer synchronizers.
// Assumes ADDR_W <= 15, DATA_W >= 8, and rst_n is held for at least two
// edges of each clock.
module dual_clk_pflag_fifo
    import pf_fifo_pkg::*;
#(
    parameter int DATA_W  = 9,
    parameter int ADDR_W  = 10,
    parameter int DEF_OFS = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en1,
    input  logic              wr_en2_ld,
    input  logic              rd_en1,
    input  logic              rd_en2,
    input  logic              out_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              almost_full,
    output logic              empty,
    output logic              almost_empty
);

    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wbin, wgray, rbin, rgray;
    logic [PTR_W-1:0]  rbin_in_w, wbin_in_r;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [DATA_W-1:0] ram_q, rd_q;
    logic              mem_we, w_load_mode, r_load_mode;
    ofs_bank_t         ofs;

    pf_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (ram_q)
    );

    pf_wr_ctrl #(.ADDR_W(ADDR_W), .DEF_OFS(DEF_OFS)) u_wr (
        .clk         (wr_clk),
        .rst_n       (rst_n),
        .en1         (wr_en1),
        .en2_ld      (wr_en2_ld),
        .ofs_din     (wr_data[OFS_BYTE_W-1:0]),
        .rptr_bin    (rbin_in_w),
        .mem_we      (mem_we),
        .mem_addr    (waddr),
        .wbin        (wbin),
        .wgray       (wgray),
        .full        (full),
        .almost_full (almost_full),
        .ofs         (ofs),
        .load_mode   (w_load_mode)
    );

    pf_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rst_n),
        .en1          (rd_en1),
        .en2          (rd_en2),
        .ld           (wr_en2_ld),
        .wptr_bin     (wbin_in_r),
        .mem_rdata    (ram_q),
        .ofs          (ofs),
        .mem_addr     (raddr),
        .rbin         (rbin),
        .rgray        (rgray),
        .rd_q         (rd_q),
        .empty        (empty),
        .almost_empty (almost_empty),
        .load_mode    (r_load_mode)
    );

    // Read pointer into the write domain
    pf_gray_sync #(.W(PTR_W)) u_sync_r2w (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .gray_in (rgray),
        .bin_out (rbin_in_w)
    );

    // Write pointer into the read domain
    pf_gray_sync #(.W(PTR_W)) u_sync_w2r (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .gray_in (wgray),
        .bin_out (wbin_in_r)
    );

    assign rd_data = out_en ? rd_q : '0;

endmodule

// File: rtl/pf_fifo_checks.sv
// Checker for dual_clk_pflag_fifo, attached with bind. Relates pointers and
// flags of each domain over time.
module pf_fifo_checks #(
    parameter int ADDR_W = 10,
    localparam int PTR_W = ADDR_W + 1
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             wr_en1,
    input logic             wr_en2_ld,
    input logic             rd_en1,
    input logic             rd_en2,
    input logic             full,
    input logic             almost_full,
    input logic             empty,
    input logic             almost_empty,
    input logic [PTR_W-1:0] wbin,
    input logic [PTR_W-1:0] rbin,
    input logic [PTR_W-1:0] wgray,
    input logic [PTR_W-1:0] rgray,
    input logic             w_load_mode,
    input logic             r_load_mode
);

    // R2: write pointer advances by at most one per edge
    p_wptr_step_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wbin - $past(wbin)) <= PTR_W'(1));

    // R3: nothing is stored while full
    p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |=> $stable(wbin));

    // R4: nothing is taken while empty
    p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |=> $stable(rbin));

    // R5: full lies inside the almost-full region
    p_full_in_af_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> almost_full);

    // R6: empty lies inside the almost-empty region
    p_empty_in_ae_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |-> almost_empty);

    // R7: Gray pointers move by one bit at most
    p_wgray_onebit_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
    p_rgray_onebit_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R10: an offset readback never pops the FIFO
    p_readback_no_pop_r10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (r_load_mode && rd_en1 && rd_en2 && wr_en2_ld) |=> $stable(rbin));

    // R12: an offset write never stores a word
    p_load_no_store_r12: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (w_load_mode && wr_en1 && wr_en2_ld) |=> $stable(wbin));

endmodule

bind dual_clk_pflag_fifo pf_fifo_checks #(.ADDR_W(ADDR_W)) u_chk (
    .wr_clk       (wr_clk),
    .rd_clk       (rd_clk),
    .rst_n        (rst_n),
    .wr_en1       (wr_en1),
    .wr_en2_ld    (wr_en2_ld),
    .rd_en1       (rd_en1),
    .rd_en2       (rd_en2),
    .full         (full),
    .almost_full  (almost_full),
    .empty        (empty),
    .almost_empty (almost_empty),
    .wbin         (wbin),
    .rbin         (rbin),
    .wgray        (wgray),
    .rgray        (rgray),
    .w_load_mode  (w_load_mode),
    .r_load_mode  (r_load_mode)
);

// File: tb/sim_dual_clk_pflag_fifo.sv
// Bench: both clocks from one 125 MHz source, so every flag latency is exact.
// A behavioural model (queue plus pointer history) is compared every cycle.
module sim_dual_clk_pflag_fifo;

    localparam int DW = 9;
    localparam int AW = 10;
    localparam int D  = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_en1 = 1'b0, wr_en2_ld = 1'b1, rd_en1 = 1'b0, rd_en2 = 1'b0, out_en = 1'b1;
    logic [DW-1:0] rd_data;
    logic          full, almost_full, empty, almost_empty;

    dual_clk_pflag_fifo #(.DATA_W(DW), .ADDR_W(AW), .DEF_OFS(7)) u0 (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_data(wr_data),
        .wr_en1(wr_en1), .wr_en2_ld(wr_en2_ld), .rd_en1(rd_en1), .rd_en2(rd_en2),
        .out_en(out_en), .rd_data(rd_data), .full(full), .almost_full(almost_full),
        .empty(empty), .almost_empty(almost_empty)
    );

    int nchk = 0, nerr = 0;

    // Model state
    logic [DW-1:0] m_q[$];
    logic [DW-1:0] m_hold;
    logic [7:0]    m_ofs[4];
    bit  m_load, m_full, m_af, m_empty, m_ae;
    int  m_w, m_r, w1, w2, w3, r1, r2, r3, m_wslot, m_rslot;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int ae_off, af_off;
        bit wacc, oload, rback, racc;
        if (!rst_n) begin
            m_load = !wr_en2_ld;
            m_ofs[0] = 8'd7; m_ofs[1] = 8'd0; m_ofs[2] = 8'd7; m_ofs[3] = 8'd0;
            m_wslot = 0; m_rslot = 0;
            m_w = 0; m_r = 0; w1 = 0; w2 = 0; w3 = 0; r1 = 0; r2 = 0; r3 = 0;
            m_full = 0; m_af = 0; m_empty = 1; m_ae = 1; m_hold = '0;
            m_q.delete();
        end else begin
            ae_off = int'({m_ofs[1], m_ofs[0]}) % D;
            af_off = int'({m_ofs[3], m_ofs[2]}) % D;
            wacc  = (m_load ? (wr_en1 && !wr_en2_ld) : (wr_en1 && wr_en2_ld)) && !m_full;
            oload = m_load && wr_en1 && wr_en2_ld;
            rback = m_load && wr_en2_ld && rd_en1 && rd_en2;
            racc  = rd_en1 && rd_en2 && !rback && !m_empty;
            if (wacc) m_q.push_back(wr_data);
            if (racc) m_hold = m_q.pop_front();
            else if (rback) begin
                m_hold = {1'b0, m_ofs[m_rslot]};
                m_rslot = (m_rslot + 1) % 4;
            end
            if (oload) begin
                m_ofs[m_wslot] = wr_data[7:0];
                m_wslot = (m_wslot + 1) % 4;
            end
            w3 = w2; w2 = w1; w1 = m_w; if (wacc) m_w++;
            r3 = r2; r2 = r1; r1 = m_r; if (racc) m_r++;
            m_full  = (m_w - r3) == D;
            m_af    = (m_w - r3) >= D - af_off;
            m_empty = (w3 - m_r) == 0;
            m_ae    = (w3 - m_r) <= ae_off;
        end
    endtask

    task automatic compare();
        check("R3 full", full, m_full);
        check("R5 almost_full", almost_full, m_af);
        check("R4 empty", empty, m_empty);
        check("R6 almost_empty", almost_empty, m_ae);
        check(out_en ? "R2 rd_data" : "R11 rd_data gated", rd_data, out_en ? m_hold : '0);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        wr_en1 = 0; rd_en1 = 0; rd_en2 = 0;
    endtask

    task automatic do_reset(bit ld_level);
        rst_n = 0; wr_en2_ld = ld_level; idle();
        repeat (4) tick();
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL R2 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int n;
        // Normal mode
        do_reset(1'b1);
        tick();
        check("R1 empty", empty, 1); check("R1 almost_empty", almost_empty, 1);
        check("R1 full", full, 0);   check("R1 almost_full", almost_full, 0);
        check("R1 rd_data", rd_data, 0);

        // R8: wr_en1 alone stores nothing in normal mode
        wr_en1 = 1; wr_en2_ld = 0; wr_data = 9'h055; tick(); idle();
        repeat (4) tick();
        check("R8 single enable ignored", empty, 1);

        // R7: exact empty-clear latency
        wr_en1 = 1; wr_en2_ld = 1; wr_data = 9'h1A1; tick(); idle();
        n = 0;
        for (int i = 0; i < 6; i++) begin tick(); n++; if (!empty) break; end
        check("R7 empty clear latency", n, 3);
        for (int i = 0; i < 4; i++) begin wr_en1 = 1; wr_data = DW'(9'h100 + i); tick(); end
        idle(); repeat (4) tick();

        // R4: one read enable is not a read
        rd_en1 = 1; repeat (2) tick(); rd_en1 = 0; rd_en2 = 1; repeat (2) tick();
        check("R4 single read enable", rd_data, 0);
        rd_en1 = 1; rd_en2 = 1; repeat (9) tick(); idle();
        check("R2 last word order", rd_data, 9'h103);

        // R11: gate
        out_en = 0; tick(); check("R11 gated zero", rd_data, 0); out_en = 1; tick();

        // Fill past capacity, then mixed traffic around full
        wr_en2_ld = 1;
        for (int i = 0; i < D + 20; i++) begin wr_en1 = 1; wr_data = DW'(i * 7); tick(); end
        check("R3 full after fill", full, 1);
        for (int i = 0; i < 300; i++) begin
            wr_en1 = 1; wr_data = DW'(i ^ 9'h0AA);
            rd_en1 = (i % 3 != 0); rd_en2 = 1; tick();
        end
        idle();
        for (int i = 0; i < D + 40; i++) begin rd_en1 = 1; rd_en2 = 1; out_en = (i % 5 != 4); tick(); end
        idle(); out_en = 1; tick();
        check("R4 empty after drain", empty, 1);

        // Load mode
        do_reset(1'b0);
        tick();
        wr_en2_ld = 1; rd_en1 = 1; rd_en2 = 1;
        tick(); check("R10 readback slot0 default", rd_data, 7);
        tick(); check("R10 readback slot1 default", rd_data, 0);
        tick(); check("R10 readback slot2 default", rd_data, 7);
        tick(); check("R10 readback slot3 default", rd_data, 0);
        idle();
        wr_en1 = 1;
        wr_data = 9'h105; tick();
        wr_data = 9'h000; tick();
        wr_data = 9'h02C; tick();
        wr_data = 9'h101; tick();
        wr_data = 9'h00A; tick();
        idle(); repeat (4) tick();
        check("R12 offset write stores nothing", empty, 1);
        rd_en1 = 1; rd_en2 = 1;
        tick(); check("R9 slot0 rewritten by wrap", rd_data, 9'h00A);
        tick(); check("R9 slot1", rd_data, 9'h000);
        tick(); check("R9 slot2 low byte", rd_data, 9'h02C);
        tick(); check("R9 slot3 bit8 dropped", rd_data, 9'h001);
        tick(); check("R10 readback wraps", rd_data, 9'h00A);
        idle(); wr_en2_ld = 0; tick();
        check("R10 readback did not pop", empty, 1);

        // R12 / R5 / R6: thresholds AF = 300, AE = 10
        for (int i = 0; i < D + 8; i++) begin wr_en1 = 1; wr_data = DW'(i * 3 + 1); tick(); end
        idle(); repeat (4) tick();
        check("R12 load-mode store reached full", full, 1);
        check("R5 almost_full at full", almost_full, 1);
        for (int i = 0; i < D + 8; i++) begin rd_en1 = 1; rd_en2 = 1; tick(); end
        idle(); repeat (4) tick();
        check("R6 almost_empty after drain", almost_empty, 1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule